// File: doc/BRIEF.md
# Indirect CSR Access Window Decoder

This block sits beside a processor's CSR file and serves an indirect register access scheme. There are three privilege levels: machine, supervisor and virtual supervisor. Each level owns one select register and a short group of data windows. A CSR access that lands on a data window is not served locally. It is forwarded to a hidden register space, addressed by the level's stored select value together with the number of the window that was used. Select values that fall in the interrupt-file range, reached through the first window, go to a separate interrupt port instead.

Each request is decoded in the cycle it is presented. The block first checks the extension enables, the privilege level, virtualization and the state-enable gate bits. It then either updates a select register with a masked read-modify-write, or forwards the access to the backend or the interrupt port. Both ports answer within the same cycle. One cycle after the request, the block returns registered read data and a result code.

When virtualization is active, supervisor-level numbers are redirected to the virtual-supervisor level. A virtual-supervisor window that selects an unimplemented register then reports a virtual-instruction fault rather than an illegal instruction.

Top module: `icsr_window_dec`

## Requirements
- R1: Each level has a 16-address page: machine 0x35X, supervisor 0x15X, virtual supervisor 0x25X. In that page, offset 0 is the select register, offset 1 is window 1, and offsets 2, 3, 5, 6 and 7 are windows 2 to 6. Offset 4, offsets 8 to 15 and every address outside the three pages answer with code 1 (illegal). The backend window index is always in the range 1 to 6.
- R2: The op encoding is 0 read, 1 write, 2 set and 3 clear. These give a (new, mask) pair of (wdata, all ones), (all ones, wdata) and (0, wdata); a read gives a mask of 0. A legal select access returns the prior value, zero-extended, and stores (old & ~m) | (new & m). The selects reset to 0 and change only on a legal select access.
- R3: The select mask m is the op mask ANDed with 0xFFF when either indirect extension enable is set. Otherwise it is ANDed with 0x1FF.
- R4: The machine select and window 1 need the interrupt enable or the machine indirect enable. The supervisor and virtual-supervisor select and window 1 need any of the three enables. Machine windows 2 to 6 need the machine indirect enable. Supervisor and virtual-supervisor windows 2 to 6 need either indirect enable. A missing enable gives code 1.
- R5: Privilege is encoded U=0, S=1, M=3. The machine page needs M, else code 1. The other two pages need S or M. A user access to them gives code 2 when virtualized and code 1 otherwise.
- R6: With virtualization active, a 0x15X address is decoded as the matching 0x25X address. A direct 0x25X address while virtualized gives code 2.
- R7: Windows 2 to 6 are gated by two bits. gate_m only counts when the interrupt enable or the machine indirect enable is set; gate_h only counts when the interrupt enable or the supervisor indirect enable is set. Below M privilege, a gate_m that does not count gives code 1. Otherwise, while virtualized, a gate_h that does not count gives code 2.
- R8: Window 1 goes to the interrupt port when the select value is in 0x030..0x0FF and the interrupt enable is set. Otherwise it goes to the backend if either indirect enable is set, and otherwise gives code 1. Windows 2 to 6 always go to the backend.
- R9: The backend and interrupt ports carry the select value, the window index, the level (M=0, S=1, VS=2), and the new data and mask. When a port reports not implemented, the code is 2 if the level is virtual supervisor and virtualization is active, and 1 otherwise. On success the read data is the port's data. Whenever the code is not 0, the read data is 0.
- R10: rsp_valid, rsp_code (0 none, 1 illegal instruction, 2 virtual-instruction fault) and rsp_rdata are registered. They answer a request one clock after it is presented, and rsp_valid is low in the cycle after a clock with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CSR access present |
| req_addr | input | 12 | CSR number |
| req_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| req_wdata | input | XLEN | Operand data |
| req_priv | input | 2 | Current privilege U=0, S=1, M=3 |
| req_virt | input | 1 | Virtualization active |
| en_aia | input | 1 | Interrupt-architecture extension present |
| en_mind | input | 1 | Machine-level indirect extension present |
| en_sind | input | 1 | Supervisor-level indirect extension present |
| gate_m | input | 1 | Machine state-enable select bit |
| gate_h | input | 1 | Hypervisor state-enable select bit |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Result code |
| rsp_rdata | output | XLEN | Read data |
| be_valid | output | 1 | Backend access |
| be_level | output | 2 | Backend level |
| be_sel | output | SEL_W | Backend select value |
| be_win | output | 3 | Backend window index 1..6 |
| be_wdata | output | XLEN | Backend new data |
| be_wmask | output | XLEN | Backend write mask |
| be_rdata | input | XLEN | Backend read data |
| be_nimpl | input | 1 | Backend register not implemented |
| irq_valid | output | 1 | Interrupt-port access |
| irq_level | output | 2 | Interrupt-port level |
| irq_sel | output | SEL_W | Interrupt-port select value |
| irq_wdata | output | XLEN | Interrupt-port new data |
| irq_wmask | output | XLEN | Interrupt-port write mask |
| irq_rdata | input | XLEN | Interrupt-port read data |
| irq_nimpl | input | 1 | Interrupt register not implemented |

## Verification
The assertions assume that the backend and interrupt ports answer combinationally in the cycle they are addressed. They also assume that the enable and gate inputs stay constant while a request is outstanding. The bench meets both assumptions. It models each port with a pure function of the select value, window and level, and it changes the enables and gates only between requests. The bench also never presents machine privilege together with virtualization. The sweep covers every address of the three pages and one foreign page, with all privileges, both virtualization states, every enable combination and every gate combination, against select values chosen to fall inside and outside the interrupt range and onto unimplemented registers.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
  localparam int CSR_AW = 12;

  typedef enum logic [1:0] {LVL_M = 2'd0, LVL_S = 2'd1, LVL_VS = 2'd2} lvl_e;
  typedef enum logic [1:0] {RC_NONE = 2'd0, RC_ILL = 2'd1, RC_VIRT = 2'd2} rc_e;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_SET   = 2'd2;
  localparam logic [1:0] OP_CLEAR = 2'd3;

  localparam logic [7:0] PAGE_M  = 8'h35;
  localparam logic [7:0] PAGE_S  = 8'h15;
  localparam logic [7:0] PAGE_VS = 8'h25;

  localparam logic [2:0] WIN_SEL  = 3'd0;
  localparam logic [2:0] WIN_NONE = 3'd7;

  typedef struct packed {
    logic       hit;
    lvl_e       lvl;
    logic [2:0] win;
    logic       direct_vs;
  } dec_t;

  // Offset inside a page to window number; offset 4 is a hole.
  function automatic logic [2:0] win_of(input logic [3:0] off);
    case (off)
      4'd0:    win_of = WIN_SEL;
      4'd1:    win_of = 3'd1;
      4'd2:    win_of = 3'd2;
      4'd3:    win_of = 3'd3;
      4'd5:    win_of = 3'd4;
      4'd6:    win_of = 3'd5;
      4'd7:    win_of = 3'd6;
      default: win_of = WIN_NONE;
    endcase
  endfunction
endpackage

// File: rtl/icsr_addr_decode.sv
module icsr_addr_decode
  import icsr_pkg::*;
(
  input  logic [CSR_AW-1:0] addr,
  input  logic              virt,
  output dec_t              dec
);
  logic [7:0] page;

  always_comb begin
    page = addr[CSR_AW-1:4];
    if (virt && page == PAGE_S) page = PAGE_VS;
    dec           = '0;
    dec.direct_vs = (addr[CSR_AW-1:4] == PAGE_VS);
    dec.win       = win_of(addr[3:0]);
    case (page)
      PAGE_M:  begin dec.hit = 1'b1; dec.lvl = LVL_M;  end
      PAGE_S:  begin dec.hit = 1'b1; dec.lvl = LVL_S;  end
      PAGE_VS: begin dec.hit = 1'b1; dec.lvl = LVL_VS; end
      default: begin dec.hit = 1'b0; dec.lvl = LVL_M;  end
    endcase
    if (dec.win == WIN_NONE) dec.hit = 1'b0;
  end
endmodule

// File: rtl/icsr_access_check.sv
module icsr_access_check
  import icsr_pkg::*;
(
  input  dec_t       dec,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       en_aia,
  input  logic       en_mind,
  input  logic       en_sind,
  input  logic       gate_m,
  input  logic       gate_h,
  output rc_e        code
);
  logic ind_any, ext_ok, upper_win, gm_eff, gh_eff;

  always_comb begin
    ind_any   = en_mind | en_sind;
    upper_win = (dec.win != WIN_SEL) && (dec.win != 3'd1);
    gm_eff    = gate_m & (en_aia | en_mind);
    gh_eff    = gate_h & (en_aia | en_sind);
    if (!upper_win)
      ext_ok = (dec.lvl == LVL_M) ? (en_aia | en_mind) : (en_aia | ind_any);
    else
      ext_ok = (dec.lvl == LVL_M) ? en_mind : ind_any;

    code = RC_NONE;
    if (!dec.hit || !ext_ok) begin
      code = RC_ILL;
    end else if (dec.lvl == LVL_M) begin
      if (priv != PRV_M) code = RC_ILL;
    end else if (dec.direct_vs && virt) begin
      code = RC_VIRT;
    end else if (priv == PRV_U) begin
      code = virt ? RC_VIRT : RC_ILL;
    end
    if (code == RC_NONE && upper_win) begin
      if (priv != PRV_M && !gm_eff) code = RC_ILL;
      else if (virt && !gh_eff)     code = RC_VIRT;
    end
  end
endmodule

// File: rtl/icsr_select_bank.sv
module icsr_select_bank #(
  parameter int SEL_W = 12,
  parameter int NLVL  = 3,
  localparam int LVL_W = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [LVL_W-1:0]           wr_lvl,
  input  logic [SEL_W-1:0]           nv,
  input  logic [SEL_W-1:0]           wm,
  output logic [NLVL-1:0][SEL_W-1:0] sel_q
);
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst)
        sel_q[g] <= '0;
      else if (we && wr_lvl == LVL_W'(g))
        sel_q[g] <= (sel_q[g] & ~wm) | (nv & wm);
    end
  end
endmodule

// File: rtl/icsr_window_dec.sv
module icsr_window_dec
  import icsr_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              SEL_W    = 12,
  parameter int              NARROW_W = 9,
  parameter logic [SEL_W-1:0] IRQ_LO  = 12'h030,
  parameter logic [SEL_W-1:0] IRQ_HI  = 12'h0FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [11:0]       req_addr,
  input  logic [1:0]        req_op,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [1:0]        req_priv,
  input  logic              req_virt,
  input  logic              en_aia,
  input  logic              en_mind,
  input  logic              en_sind,
  input  logic              gate_m,
  input  logic              gate_h,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              be_valid,
  output logic [1:0]        be_level,
  output logic [SEL_W-1:0]  be_sel,
  output logic [2:0]        be_win,
  output logic [XLEN-1:0]   be_wdata,
  output logic [XLEN-1:0]   be_wmask,
  input  logic [XLEN-1:0]   be_rdata,
  input  logic              be_nimpl,
  output logic              irq_valid,
  output logic [1:0]        irq_level,
  output logic [SEL_W-1:0]  irq_sel,
  output logic [XLEN-1:0]   irq_wdata,
  output logic [XLEN-1:0]   irq_wmask,
  input  logic [XLEN-1:0]   irq_rdata,
  input  logic              irq_nimpl
);
  localparam int NLVL = 3;
  localparam logic [SEL_W-1:0] MASK_FULL   = '1;
  localparam logic [SEL_W-1:0] MASK_NARROW = SEL_W'((1 << NARROW_W) - 1);

  dec_t                       dec;
  rc_e                        code_acc, code_fin, code_nf;
  logic [NLVL-1:0][SEL_W-1:0] sel_q;
  logic [SEL_W-1:0]           cur_sel, sel_mask;
  logic [XLEN-1:0]            op_nv, op_wm, rdata_fin;
  logic                       is_sel, in_irq, to_irq, to_be, ind_any, sel_we, granted;

  icsr_addr_decode u_dec (
    .addr (req_addr),
    .virt (req_virt),
    .dec  (dec)
  );

  icsr_access_check u_chk_acc (
    .dec     (dec),
    .priv    (req_priv),
    .virt    (req_virt),
    .en_aia  (en_aia),
    .en_mind (en_mind),
    .en_sind (en_sind),
    .gate_m  (gate_m),
    .gate_h  (gate_h),
    .code    (code_acc)
  );

  // Operation to (new value, write mask) pair
  always_comb begin
    case (req_op)
      OP_WRITE: begin op_nv = req_wdata; op_wm = '1;        end
      OP_SET:   begin op_nv = '1;        op_wm = req_wdata; end
      OP_CLEAR: begin op_nv = '0;        op_wm = req_wdata; end
      default:  begin op_nv = req_wdata; op_wm = '0;        end
    endcase
  end

  always_comb begin
    case (dec.lvl)
      LVL_S:   cur_sel = sel_q[1];
      LVL_VS:  cur_sel = sel_q[2];
      default: cur_sel = sel_q[0];
    endcase
  end

  assign ind_any  = en_mind | en_sind;
  assign sel_mask = ind_any ? MASK_FULL : MASK_NARROW;
  assign is_sel   = (dec.win == WIN_SEL);
  assign in_irq   = (cur_sel >= IRQ_LO) && (cur_sel <= IRQ_HI);
  assign to_irq   = !is_sel && (dec.win == 3'd1) && in_irq && en_aia;
  assign to_be    = !is_sel && !to_irq && ind_any;
  assign granted  = req_valid && (code_acc == RC_NONE);
  assign code_nf  = (dec.lvl == LVL_VS && req_virt) ? RC_VIRT : RC_ILL;

  always_comb begin
    if (code_acc != RC_NONE) code_fin = code_acc;
    else if (is_sel)         code_fin = RC_NONE;
    else if (to_irq)         code_fin = irq_nimpl ? code_nf : RC_NONE;
    else if (to_be)          code_fin = be_nimpl ? code_nf : RC_NONE;
    else                     code_fin = RC_ILL;
  end

  always_comb begin
    if (code_fin != RC_NONE) rdata_fin = '0;
    else if (is_sel)         rdata_fin = XLEN'(cur_sel);
    else if (to_irq)         rdata_fin = irq_rdata;
    else                     rdata_fin = be_rdata;
  end

  assign sel_we = granted && is_sel && (req_op != OP_READ);

  icsr_select_bank #(.SEL_W(SEL_W), .NLVL(NLVL)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .we     (sel_we),
    .wr_lvl (dec.lvl),
    .nv     (op_nv[SEL_W-1:0]),
    .wm     (op_wm[SEL_W-1:0] & sel_mask),
    .sel_q  (sel_q)
  );

  assign be_valid  = granted && to_be;
  assign be_level  = dec.lvl;
  assign be_sel    = cur_sel;
  assign be_win    = dec.win;
  assign be_wdata  = op_nv;
  assign be_wmask  = op_wm;
  assign irq_valid = granted && to_irq;
  assign irq_level = dec.lvl;
  assign irq_sel   = cur_sel;
  assign irq_wdata = op_nv;
  assign irq_wmask = op_wm;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RC_NONE;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_code  <= req_valid ? code_fin : RC_NONE;
      rsp_rdata <= req_valid ? rdata_fin : '0;
    end
  end
endmodule

// File: rtl/icsr_window_dec_chk.sv
module icsr_window_dec_chk #(
  parameter int XLEN  = 32,
  parameter int SEL_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_virt,
  input logic [3:0]       req_page_hi,
  input logic [1:0]       req_priv,
  input logic             rsp_valid,
  input logic [1:0]       rsp_code,
  input logic [XLEN-1:0]  rsp_rdata,
  input logic             be_valid,
  input logic [2:0]       be_win,
  input logic             irq_valid,
  input logic [SEL_W-1:0] sel_m,
  input logic [SEL_W-1:0] sel_s,
  input logic [SEL_W-1:0] sel_vs
);
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R9
  fault_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != 2'd0) |-> rsp_rdata == '0);
  // R1
  be_win_range_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid |-> (be_win != 3'd0 && be_win != 3'd7));
  // R8
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(be_valid && irq_valid));
  // R5
  mpage_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_page_hi == 4'h3 && req_priv != 2'd3) |=> rsp_code == 2'd1);
  // R6
  virt_fault_src_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd2) |-> $past(req_virt));
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(sel_m) && $stable(sel_s) && $stable(sel_vs)));
endmodule

bind icsr_window_dec icsr_window_dec_chk #(.XLEN(XLEN), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_virt    (req_virt),
  .req_page_hi (req_addr[11:8]),
  .req_priv    (req_priv),
  .rsp_valid   (rsp_valid),
  .rsp_code    (rsp_code),
  .rsp_rdata   (rsp_rdata),
  .be_valid    (be_valid),
  .be_win      (be_win),
  .irq_valid   (irq_valid),
  .sel_m       (sel_q[0]),
  .sel_s       (sel_q[1]),
  .sel_vs      (sel_q[2])
);

// File: tb/tb_icsr_window_dec.sv
module tb_icsr_window_dec;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0] req_op = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0] req_priv = '0;
  logic req_virt = 1'b0;
  logic en_aia = 1'b0, en_mind = 1'b0, en_sind = 1'b0, gate_m = 1'b0, gate_h = 1'b0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [31:0] rsp_rdata;
  logic be_valid, irq_valid, be_nimpl, irq_nimpl;
  logic [1:0] be_level, irq_level;
  logic [11:0] be_sel, irq_sel;
  logic [2:0] be_win;
  logic [31:0] be_wdata, be_wmask, be_rdata, irq_wdata, irq_wmask, irq_rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [11:0] mref [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  icsr_window_dec dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op),
    .req_wdata(req_wdata), .req_priv(req_priv), .req_virt(req_virt), .en_aia(en_aia),
    .en_mind(en_mind), .en_sind(en_sind), .gate_m(gate_m), .gate_h(gate_h),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
    .be_valid(be_valid), .be_level(be_level), .be_sel(be_sel), .be_win(be_win),
    .be_wdata(be_wdata), .be_wmask(be_wmask), .be_rdata(be_rdata), .be_nimpl(be_nimpl),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_sel(irq_sel),
    .irq_wdata(irq_wdata), .irq_wmask(irq_wmask), .irq_rdata(irq_rdata),
    .irq_nimpl(irq_nimpl)
  );

  // Port models: pure functions of the presented select, window and level
  always_comb begin
    be_rdata  = {8'hB0, 6'd0, be_level, 1'b0, be_win, be_sel};
    be_nimpl  = (be_sel[11:8] == 4'hF);
    irq_rdata = {8'hA0, 6'd0, irq_level, 4'd0, irq_sel};
    irq_nimpl = (irq_sel == 12'h0FE);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s addr=%h priv=%0d virt=%0d act=%h exp=%h",
               tag, what, req_addr, req_priv, req_virt, act, exp);
    end
  endtask

  // Expected behaviour taken from the requirements
  function automatic void model(input logic [11:0] a, input logic [1:0] pr, input logic v,
                                input logic [1:0] op, input logic [31:0] wd,
                                output logic [1:0] code, output logic [31:0] rd,
                                output bit we, output int wl, output logic [11:0] ns,
                                output string tag);
    logic [7:0] page;
    int lv, w;
    bit dvs, ind, ext;
    logic [11:0] cur, msk;
    logic [31:0] nv, wm;
    logic [1:0] nf;
    code = 2'd0; rd = '0; we = 0; wl = 0; ns = '0; tag = "R1";
    page = a[11:4];
    dvs = (page == 8'h25);
    if (v && page == 8'h15) page = 8'h25;
    lv = (page == 8'h35) ? 0 : (page == 8'h15) ? 1 : (page == 8'h25) ? 2 : -1;
    case (a[3:0])
      4'd0: w = 0; 4'd1: w = 1; 4'd2: w = 2; 4'd3: w = 3;
      4'd5: w = 4; 4'd6: w = 5; 4'd7: w = 6;
      default: w = -1;
    endcase
    if (lv < 0 || w < 0) begin code = 2'd1; return; end
    ind = en_mind || en_sind;
    if (w <= 1) ext = (lv == 0) ? (en_aia || en_mind) : (en_aia || ind);
    else        ext = (lv == 0) ? en_mind : ind;
    if (!ext) begin code = 2'd1; tag = "R4"; return; end
    tag = "R5";
    if (lv == 0) begin
      if (pr != 2'd3) begin code = 2'd1; return; end
    end else begin
      if (dvs && v) begin code = 2'd2; tag = "R6"; return; end
      if (pr == 2'd0) begin code = v ? 2'd2 : 2'd1; return; end
    end
    if (w >= 2) begin
      tag = "R7";
      if (pr != 2'd3 && !(gate_m && (en_aia || en_mind))) begin code = 2'd1; return; end
      if (v && !(gate_h && (en_aia || en_sind))) begin code = 2'd2; return; end
    end
    cur = mref[lv];
    case (op)
      2'd1: begin nv = wd; wm = '1; end
      2'd2: begin nv = '1; wm = wd; end
      2'd3: begin nv = '0; wm = wd; end
      default: begin nv = wd; wm = '0; end
    endcase
    nf = (lv == 2 && v) ? 2'd2 : 2'd1;
    if (w == 0) begin
      tag = ind ? "R2" : "R3";
      msk = ind ? 12'hFFF : 12'h1FF;
      rd = {20'd0, cur};
      we = (op != 2'd0); wl = lv;
      ns = (cur & ~(wm[11:0] & msk)) | (nv[11:0] & wm[11:0] & msk);
    end else if (w == 1 && en_aia && cur >= 12'h030 && cur <= 12'h0FF) begin
      tag = "R8";
      if (cur == 12'h0FE) begin code = nf; tag = "R9"; end
      else rd = {8'hA0, 6'd0, 2'(lv), 4'd0, cur};
    end else if (ind) begin
      tag = "R9";
      if (cur[11:8] == 4'hF) code = nf;
      else rd = {8'hB0, 6'd0, 2'(lv), 1'b0, 3'(w), cur};
    end else begin
      code = 2'd1; tag = "R8";
    end
  endfunction

  task automatic acc(input logic [11:0] a, input logic [1:0] pr, input logic v,
                     input logic [1:0] op, input logic [31:0] wd);
    logic [1:0] ec; logic [31:0] er; bit we; int wl; logic [11:0] ns; string tag;
    model(a, pr, v, op, wd, ec, er, we, wl, ns, tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_priv = pr; req_virt = v; req_op = op; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_code == ec, tag, "code", 32'(rsp_code), 32'(ec));
    chk(rsp_rdata == er, tag, "rdata", rsp_rdata, er);
    if (we) mref[wl] = ns;
  endtask

  initial begin
    logic [11:0] selset [4];
    logic [1:0] privs [3];
    logic [7:0] pages [4];
    selset[0] = 12'h040; selset[1] = 12'h123; selset[2] = 12'hF05; selset[3] = 12'h0FE;
    privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
    pages[0] = 8'h15; pages[1] = 8'h25; pages[2] = 8'h35; pages[3] = 8'h45;
    for (int i = 0; i < 3; i++) mref[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    // R2 reset value of the selects
    en_aia = 1; en_mind = 1; en_sind = 1; gate_m = 1; gate_h = 1;
    acc(12'h350, 2'd3, 1'b0, 2'd0, 32'h0);
    acc(12'h150, 2'd3, 1'b0, 2'd0, 32'h0);
    acc(12'h250, 2'd3, 1'b0, 2'd0, 32'h0);
    for (int e = 0; e < 8; e++) begin
      en_aia = e[0]; en_mind = e[1]; en_sind = e[2];
      for (int k = 0; k < 4; k++) begin
        gate_m = 1; gate_h = 1;
        acc(12'h350, 2'd3, 1'b0, 2'd1, {20'hFFFFF, selset[k]});
        acc(12'h150, 2'd3, 1'b0, 2'd1, {20'd0, selset[(k + 1) % 4]});
        acc(12'h250, 2'd3, 1'b0, 2'd1, {20'd0, selset[(k + 2) % 4]});
        for (int g = 0; g < 4; g++) begin
          gate_m = g[0]; gate_h = g[1];
          for (int p = 0; p < 4; p++)
            for (int lo = 0; lo < 16; lo++)
              for (int pi = 0; pi < 3; pi++)
                for (int v = 0; v < 2; v++)
                  if (!(privs[pi] == 2'd3 && v == 1))
                    acc({pages[p], 4'(lo)}, privs[pi], v[0], 2'd0, 32'h0);
        end
      end
    end
    // R2 set and clear ops on the supervisor select, R3 full mask
    en_aia = 1; en_mind = 0; en_sind = 1; gate_m = 1; gate_h = 1;
    acc(12'h150, 2'd1, 1'b0, 2'd1, 32'h0000_00F0);
    acc(12'h150, 2'd1, 1'b0, 2'd2, 32'h0000_F00F);
    acc(12'h150, 2'd1, 1'b0, 2'd3, 32'h0000_00F0);
    acc(12'h150, 2'd1, 1'b0, 2'd0, 32'h0);
    // R6 virtualized supervisor select write lands on the virtual-supervisor select
    acc(12'h150, 2'd1, 1'b1, 2'd1, 32'h0000_0AB5);
    acc(12'h250, 2'd1, 1'b0, 2'd0, 32'h0);
    acc(12'h150, 2'd1, 1'b0, 2'd0, 32'h0);
    @(negedge clk);
    // R10 no request, no response
    chk(rsp_valid == 1'b0, "R10", "idle rsp_valid", 32'(rsp_valid), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule